// File: doc/BRIEF.md
# Physical Block Write Protector

This block screens every physical memory access against a map of write-protect flags. Memory is divided into 1K-word blocks, and each block has one flag. Flags are grouped into 16-bit map words, so one word covers a 16K-word region. A write to a flagged block is reported as a violation. Reads are never reported. A global write lock is also present. Reset engages it, and the lock covers every block until a single enable command releases it.

After reset the map is wiped to "no protection" by a fixed-length sequence. No check completes until that sequence ends. A one-word cache holds the map word for the region used most recently. An access that stays in that region is answered one cycle after its strobe is sampled. An access to any other region costs one extra cycle while the cache refills. The fault output is held in the fault state whenever no access is in progress. It releases only when a finished check finds the target block unprotected. A separate valid output marks that the result is settled.

Top module: `blk_write_guard`

## Requirements
- R1: The map holds 64 words of 16 bits. Physical address bits [19:14] select the word, and each word covers one 16K-word region.
- R2: Within a map word, bit (15 − address[13:10]) guards the 1K-word block addressed by address[13:10]. The most significant bit therefore guards the lowest block of the region.
- R3: A write (`acc_wr`=1) to a block whose flag is 1 finishes with `blk_fault`=1 and `chk_valid`=1. A write to an unflagged block finishes with `blk_fault`=0. A read (`acc_wr`=0) always finishes with `blk_fault`=0.
- R4: Reset starts a wipe of CLR_CYCLES (default 256) clock cycles that clears every map word. During the wipe `chk_valid` stays 0, and any access stays pending until the wipe ends. Map writes issued during the wipe are dropped.
- R5: `gprot_active` is 1 after reset and becomes 0 in the cycle after a `gprot_clr` pulse. It then stays 0 until the next reset. While it is 1, every write finishes with `blk_fault`=1, whatever the map holds.
- R6: If the access falls in the cached region, `chk_valid` rises one cycle after `acc_req` is first sampled high. If the access falls in another region, or is the first access after reset, `chk_valid` rises after two cycles.
- R7: A map write to the cached region's word also updates the cache in the same cycle. The next access to that region is still a one-cycle hit, and it is judged against the new word.
- R8: One cycle after `acc_req` is sampled low, `blk_fault`=1 and `chk_valid`=0. `blk_fault` is 0 only while `chk_valid` is 1.
- R9: While `acc_req` stays high after a completed check, `blk_fault` and `chk_valid` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access strobe; held high for the whole access |
| acc_addr | input | 20 | Physical word address of the access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| map_we | input | 1 | Map word write enable |
| map_idx | input | 6 | Map word index (address bits [19:14] of the region) |
| map_data | input | 16 | Map word contents |
| gprot_clr | input | 1 | Enable command; releases the global write lock |
| blk_fault | output | 1 | 1 = violation or not yet checked; 0 = access allowed |
| chk_valid | output | 1 | 1 = check result settled |
| gprot_active | output | 1 | 1 = global write lock engaged |

## Verification
Several rules are checked by assertions on every cycle:
- the fault output drops only while the valid output is high;
- both outputs return to their idle values after the strobe falls;
- no result appears during the wipe;
- reads are never flagged, and writes are always flagged while the lock holds;
- a refill leaves the cache tagged with the requested region;
- a write to the cached word lands in the cache.

Other behaviour can only be shown by the bench's scenarios, which compare against its own model of the map and of the cached region:
- the reversed bit order within a map word;
- the one-cycle versus two-cycle latency for each region change;
- the dropping of map writes issued during the wipe;
- the correct verdict after the cached word is rewritten.

// File: rtl/blk_guard_pkg.sv
package blk_guard_pkg;
    localparam int unsigned PA_W    = 20;
    localparam int unsigned MAP_W   = 16;
    localparam int unsigned BLK_LSB = 10;
    localparam int unsigned BSEL_W  = $clog2(MAP_W);
    localparam int unsigned REG_LSB = BLK_LSB + BSEL_W;
    localparam int unsigned IDX_W   = PA_W - REG_LSB;
    localparam int unsigned DEPTH   = 1 << IDX_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [MAP_W-1:0]  map_t;
    typedef logic [BSEL_W-1:0] bsel_t;

    typedef struct packed {
        idx_t                 region;
        bsel_t                blk;
        logic [BLK_LSB-1:0]   off;
    } paddr_t;

    typedef struct packed {
        logic vld;
        idx_t tag;
        map_t word;
    } cache_ent_t;

    typedef enum logic [1:0] {CK_IDLE, CK_FILL, CK_HOLD} ck_state_e;

    // Highest bit guards block 0 of the region.
    function automatic logic guard_bit(map_t w, bsel_t b);
        bsel_t rev;
        rev = bsel_t'(MAP_W - 1) - b;
        return w[rev];
    endfunction
endpackage

// File: rtl/blk_guard_wipe.sv
module blk_guard_wipe
    import blk_guard_pkg::*;
#(
    parameter int unsigned CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    output logic busy,
    output logic wipe_we,
    output idx_t wipe_idx
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt != CNT_W'(CYCLES))
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        busy     = (cnt != CNT_W'(CYCLES));
        wipe_we  = busy && (32'(cnt) < DEPTH);
        wipe_idx = idx_t'(cnt);
    end

    // R4
    wipe_done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);
endmodule

// File: rtl/blk_guard_map.sv
module blk_guard_map
    import blk_guard_pkg::*;
(
    input  logic clk,
    input  logic wipe_we,
    input  idx_t wipe_idx,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  map_t wr_word,
    input  idx_t rd_idx,
    output map_t rd_word
);
    map_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wipe_we)
            mem[wipe_idx] <= '0;
        else if (wr_en)
            mem[wr_idx] <= wr_word;
    end

    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/blk_guard_cache.sv
module blk_guard_cache
    import blk_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t look_tag,
    input  logic fill,
    input  map_t fill_word,
    input  logic upd_en,
    input  idx_t upd_idx,
    input  map_t upd_word,
    output logic hit,
    output map_t word
);
    cache_ent_t q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (fill)
            q <= '{vld: 1'b1, tag: look_tag, word: fill_word};
        else if (upd_en && q.vld && (upd_idx == q.tag))
            q.word <= upd_word;
    end

    assign hit  = q.vld && (q.tag == look_tag);
    assign word = q.word;

    // R6
    fill_tags_region_chk: assert property (@(posedge clk) disable iff (rst)
        fill |=> (q.vld && q.tag == $past(look_tag)));

    // R7
    coherent_update_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && q.vld && upd_idx == q.tag && !fill) |=> (word == $past(upd_word)));
endmodule

// File: rtl/blk_write_guard.sv
module blk_write_guard
    import blk_guard_pkg::*;
#(
    parameter int unsigned CLR_CYCLES = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_req,
    input  logic [PA_W-1:0]  acc_addr,
    input  logic             acc_wr,
    input  logic             map_we,
    input  logic [IDX_W-1:0] map_idx,
    input  logic [MAP_W-1:0] map_data,
    input  logic             gprot_clr,
    output logic             blk_fault,
    output logic             chk_valid,
    output logic             gprot_active
);
    paddr_t    pa;
    ck_state_e st;
    logic      busy, wipe_we, map_ok, hit, fill, viol;
    idx_t      wipe_idx;
    map_t      rd_word, fill_word, c_word;
    logic      fault_q, valid_q, gprot_q;

    assign pa     = paddr_t'(acc_addr);
    assign map_ok = map_we && !busy;

    blk_guard_wipe #(.CYCLES(CLR_CYCLES)) u_wipe (
        .clk(clk), .rst(rst), .busy(busy), .wipe_we(wipe_we), .wipe_idx(wipe_idx)
    );

    blk_guard_map u_map (
        .clk(clk), .wipe_we(wipe_we), .wipe_idx(wipe_idx),
        .wr_en(map_ok), .wr_idx(map_idx), .wr_word(map_data),
        .rd_idx(pa.region), .rd_word(rd_word)
    );

    // A map write in the same cycle as a refill must reach the cache too.
    assign fill_word = (map_ok && map_idx == pa.region) ? map_data : rd_word;
    assign fill      = (st == CK_IDLE) && acc_req && !busy && !hit;

    blk_guard_cache u_cache (
        .clk(clk), .rst(rst), .look_tag(pa.region),
        .fill(fill), .fill_word(fill_word),
        .upd_en(map_ok), .upd_idx(map_idx), .upd_word(map_data),
        .hit(hit), .word(c_word)
    );

    assign viol = acc_wr && (gprot_q || guard_bit(c_word, pa.blk));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CK_IDLE;
            fault_q <= 1'b1;
            valid_q <= 1'b0;
            gprot_q <= 1'b1;
        end else begin
            if (gprot_clr)
                gprot_q <= 1'b0;
            unique case (st)
                CK_IDLE: begin
                    if (acc_req && !busy) begin
                        if (hit) begin
                            st      <= CK_HOLD;
                            valid_q <= 1'b1;
                            fault_q <= viol;
                        end else begin
                            st <= CK_FILL;
                        end
                    end
                end
                CK_FILL: begin
                    if (!acc_req) begin
                        st <= CK_IDLE;
                    end else begin
                        st      <= CK_HOLD;
                        valid_q <= 1'b1;
                        fault_q <= viol;
                    end
                end
                CK_HOLD: begin
                    if (!acc_req) begin
                        st      <= CK_IDLE;
                        valid_q <= 1'b0;
                        fault_q <= 1'b1;
                    end
                end
                default: st <= CK_IDLE;
            endcase
        end
    end

    assign blk_fault    = fault_q;
    assign chk_valid    = valid_q;
    assign gprot_active = gprot_q;

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> (blk_fault && !chk_valid));

    // R8
    fault_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_fault |-> chk_valid);

    // R4
    no_result_in_wipe_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !chk_valid);

    // R5
    gprot_release_chk: assert property (@(posedge clk) disable iff (rst)
        gprot_clr |=> !gprot_active);

    // R5
    gprot_flags_write_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && acc_wr && gprot_active) |-> blk_fault);

    // R3
    read_never_flagged_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !acc_wr) |-> !blk_fault);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && $past(chk_valid)) |-> $stable(blk_fault));

    // R6
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chk_valid) |-> $past(acc_req));
endmodule

// File: tb/blk_write_guard_bench.sv
`timescale 1ns/1ps
module blk_write_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_req = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        map_we = 1'b0;
    logic [5:0]  map_idx = '0;
    logic [15:0] map_data = '0;
    logic        gprot_clr = 1'b0;
    logic        blk_fault, chk_valid, gprot_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] bm [64];
    int          cache_reg = -1;
    bit          gp_model = 1'b1;

    always #2.5 clk = ~clk;

    blk_write_guard u_blk_write_guard (
        .clk(clk), .rst(rst), .acc_req(acc_req), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .map_we(map_we), .map_idx(map_idx), .map_data(map_data), .gprot_clr(gprot_clr),
        .blk_fault(blk_fault), .chk_valid(chk_valid), .gprot_active(gprot_active)
    );

    // {wr, addr}: region = addr[19:14], block = addr[13:10]
    localparam logic [20:0] VEC [10] = '{
        {1'b1, 6'd1,  4'd0,  10'h011},
        {1'b0, 6'd1,  4'd0,  10'h022},
        {1'b1, 6'd1,  4'd15, 10'h3FF},
        {1'b1, 6'd1,  4'd7,  10'h000},
        {1'b1, 6'd2,  4'd8,  10'h100},
        {1'b1, 6'd2,  4'd11, 10'h001},
        {1'b1, 6'd2,  4'd12, 10'h002},
        {1'b0, 6'd2,  4'd9,  10'h003},
        {1'b1, 6'd1,  4'd1,  10'h004},
        {1'b1, 6'd63, 4'd0,  10'h005}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put_map(input logic [5:0] idx, input logic [15:0] data, input bit taken);
        @(negedge clk);
        map_we = 1'b1; map_idx = idx; map_data = data;
        @(negedge clk);
        map_we = 1'b0;
        if (taken) bm[idx] = data;
    endtask

    // Runs one access, compares verdict and latency with the bench model.
    task automatic access(input logic [19:0] addr, input bit wr, input int min_wait);
        int  reg_i, blk_i, lat, exp_lat;
        bit  exp_f;
        reg_i = int'(addr[19:14]);
        blk_i = int'(addr[13:10]);
        exp_f = wr && (gp_model || bm[reg_i][15 - blk_i]);
        exp_lat = (reg_i == cache_reg) ? 1 : 2;
        @(negedge clk);
        acc_addr = addr; acc_wr = wr; acc_req = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!chk_valid && lat < 400);
        if (min_wait > 0)
            check(lat > min_wait, "R4 wait through wipe", lat, min_wait);
        else
            check(lat == exp_lat, "R6 latency", lat, exp_lat);
        check(blk_fault == exp_f, wr ? "R3/R2/R5 write verdict" : "R3 read verdict",
              int'(blk_fault), int'(exp_f));
        cache_reg = reg_i;
        cyc(3);
        check(chk_valid && blk_fault == exp_f, "R9 held result", int'(blk_fault), int'(exp_f));
        acc_req = 1'b0;
        @(negedge clk);
        check(blk_fault && !chk_valid, "R8 released to idle",
              int'({blk_fault, chk_valid}), 2);
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) bm[i] = '0;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check(blk_fault == 1'b1, "R8 reset fault", int'(blk_fault), 1);
        check(chk_valid == 1'b0, "R4 reset valid", int'(chk_valid), 0);
        check(gprot_active == 1'b1, "R5 reset lock", int'(gprot_active), 1);

        // R4: map write during wipe is dropped; access waits for wipe end
        cyc(5);
        put_map(6'd3, 16'hFFFF, 1'b0);
        cyc(3);
        access({6'd0, 4'd2, 10'h0}, 1'b0, 200);

        // R5: lock flags writes to clean blocks, then releases
        access({6'd0, 4'd5, 10'h0}, 1'b1, 0);
        @(negedge clk);
        gprot_clr = 1'b1;
        @(negedge clk);
        gprot_clr = 1'b0;
        gp_model = 1'b0;
        check(gprot_active == 1'b0, "R5 lock released", int'(gprot_active), 0);
        access({6'd0, 4'd5, 10'h0}, 1'b1, 0);
        access({6'd3, 4'd0, 10'h0}, 1'b1, 0);   // R4 dropped write left region 3 clean

        // R1 R2: program map words
        put_map(6'd1, 16'h8001, 1'b1);
        put_map(6'd2, 16'h00F0, 1'b1);
        for (int v = 0; v < 10; v++)
            access(VEC[v][19:0], VEC[v][20], 0);

        // R7: rewrite the cached word and check hit with new contents
        access({6'd2, 4'd5, 10'h0}, 1'b1, 0);
        put_map(6'd2, 16'h0F00, 1'b1);
        access({6'd2, 4'd5, 10'h0}, 1'b1, 0);
        access({6'd2, 4'd9, 10'h0}, 1'b1, 0);
        check(gprot_active == 1'b0, "R5 lock stays off", int'(gprot_active), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule